// File: doc/BRIEF.md
# I2C Register-Memory Target

This block is an I2C bus target that recovers the bus from an oversampled system clock. It answers one programmable bus address, in either the 7-bit form or the 10-bit two-byte form. Behind that address sits a small byte array.

A write transaction first carries a memory address of zero to four bytes, most significant byte first. Any data bytes that follow are stored from that address upward. A read transaction returns bytes from the current pointer. The pointer advances after every data byte and wraps at the array depth. The usual way to read a location is a write of the address bytes, then a repeated START and a read.

The block raises six sticky event flags for the phases of a transfer. The flags are cleared by write-one strobes. The flags selected by a trigger mask are merged into one interrupt output. No data stream leaves the block, so every pin is a plain control or status signal. SDA is open-drain: `sda_oe` high pulls the line low.

Top module: `i2c_regtarget`

## Requirements
- R1: With `addr10` low, a first byte whose upper seven bits equal `own_addr[6:0]` is ACKed (SDA low in the ninth clock), and bit 0 selects read (1) or write (0). Any other first byte is NACKed, sets no flag, and the target stays off the bus until the next START.
- R2: With `addr10` high, the target ACKs the first byte `11110,own_addr[9:8],0` and then a second byte equal to `own_addr[7:0]`. It NACKs a wrong second byte. After such a selection, a repeated START with `11110,own_addr[9:8],1` is ACKed as a read.
- R3: A write transaction first takes `mem_abytes` address bytes, where values above 4 act as 4. These bytes arrive MSB first and are all ACKed. The assembled value appears on `mem_addr_q`. The value modulo `MEM_DEPTH` becomes the data pointer. `MEM_DEPTH` is a power of two.
- R4: Each data byte written after the address bytes is ACKed and stored at the pointer. The pointer then advances, wrapping modulo `MEM_DEPTH`.
- R5: In a read, the target drives the byte at the pointer MSB first and then advances the pointer. It continues while the controller ACKs. After a controller NACK, `sda_oe` stays low.
- R6: Flag bit positions are: [0] address match read, [1] address match write, [2] read request (each byte the target loads to send), [3] write request (each data byte received), [4] end of read, [5] end of write. Memory-address bytes raise no write request.
- R7: The end flags are set at a STOP or a repeated START that closes a selected read or write. End of write is withheld when `mem_abytes` is nonzero and no data byte was written. With `mem_abytes` zero, end of write is always raised.
- R8: Flags stay set until a cycle in which the matching bit of `evt_clr` is 1. Other bits are untouched by that strobe. A set in the same cycle as a clear wins.
- R9: `irq` is high while any flag has its trigger-mask bit set. The mask resets to `6'b110000` and is loaded from `trig_mask_wdata` when `trig_mask_we` is high.
- R10: `sda_oe` is low out of reset and in idle. It only changes while the synchronized SCL is low, except when it is released at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| own_addr | input | 10 | Target bus address |
| addr10 | input | 1 | 1 selects 10-bit addressing |
| mem_abytes | input | 3 | Memory-address byte count, 0 to 4 |
| trig_mask_we | input | 1 | Load strobe for the trigger mask |
| trig_mask_wdata | input | 6 | New trigger mask |
| evt_clr | input | 6 | Write-one-to-clear strobes for the flags |
| evt_flags | output | 6 | Sticky event flags |
| irq | output | 1 | Masked OR of the flags |
| mem_addr_q | output | 32 | Last memory address set by the controller |

## Verification
Writes are run with one, two and four address bytes, with zero address bytes, and with an out-of-range count. These runs separate byte ordering, wrap of the pointer, and clamping of the count. Reads follow both a STOP-separated address write and a repeated START. This exposes whether the pointer and the end-of-write suppression follow the transaction boundaries. Wrong 7-bit and wrong 10-bit second bytes are sent to show that a NACK leaves every flag clear. Mask loads and partial clears show that the interrupt follows only the enabled flags.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int NUM_EV = 6;
  localparam int EV_MRD = 0;
  localparam int EV_MWR = 1;
  localparam int EV_RRQ = 2;
  localparam int EV_WRQ = 3;
  localparam int EV_ERD = 4;
  localparam int EV_EWR = 5;
  localparam int MA_W   = 32;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADR1, PH_ADR2, PH_MADR, PH_WR, PH_RD, PH_HUNT
  } phase_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_mem.sv
module i2c_tgt_mem #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [PW-1:0] ridx,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cells[g] <= 8'h00;
        else if (we && widx == PW'(g)) cells[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = cells[ridx];
endmodule

// File: rtl/i2c_tgt_events.sv
module i2c_tgt_events #(
  parameter int NEV = 6,
  parameter logic [NEV-1:0] MASK_RST = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] set,
  input  logic [NEV-1:0] clr,
  input  logic           mask_we,
  input  logic [NEV-1:0] mask_wdata,
  output logic [NEV-1:0] flags,
  output logic           irq
);
  logic [NEV-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= MASK_RST;
    else if (mask_we) mask <= mask_wdata;
  end

  generate
    for (genvar g = 0; g < NEV; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[g] <= 1'b0;
        else if (set[g]) flags[g] <= 1'b1;
        else if (clr[g]) flags[g] <= 1'b0;
      end
    end
  endgenerate

  assign irq = |(flags & mask);
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [9:0]        own_addr,
  input  logic              addr10,
  input  logic [2:0]        abytes,
  input  logic [7:0]        rd_data,
  output logic [PW-1:0]     ptr,
  output logic              wr_en,
  output logic [PW-1:0]     wr_idx,
  output logic [7:0]        wr_data,
  output logic              sda_oe,
  output logic [NUM_EV-1:0] ev_set,
  output logic [MA_W-1:0]   mem_addr_q,
  output phase_t            phase
);
  phase_t      nxt;
  logic [3:0]  cnt;
  logic [7:0]  shreg, tx;
  logic [2:0]  mcnt;
  logic [MA_W-1:0] acc;
  logic        sel10, is_rd, is_wr, data_seen, rack;
  logic [MA_W-1:0] acc_new;
  logic [2:0]  bidx;
  logic        hit7, hit10hi;
  phase_t      after_addr;

  assign acc_new    = {acc[MA_W-9:0], shreg};
  assign bidx       = 3'd7 - cnt[2:0];
  assign hit7       = shreg[7:1] == own_addr[6:0];
  assign hit10hi    = shreg[7:3] == 5'b11110 && shreg[2:1] == own_addr[9:8];
  assign after_addr = (abytes != 3'd0) ? PH_MADR : PH_WR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; nxt <= PH_IDLE; cnt <= '0; shreg <= '0; tx <= '0;
      mcnt <= '0; acc <= '0; sel10 <= 1'b0; is_rd <= 1'b0; is_wr <= 1'b0;
      data_seen <= 1'b0; rack <= 1'b1; ptr <= '0; wr_en <= 1'b0;
      wr_idx <= '0; wr_data <= '0; sda_oe <= 1'b0; ev_set <= '0;
      mem_addr_q <= '0;
    end else begin
      ev_set <= '0;
      wr_en  <= 1'b0;
      if (start_det || stop_det) begin
        if (is_rd) ev_set[EV_ERD] <= 1'b1;
        if (is_wr && !(abytes != 3'd0 && !data_seen)) ev_set[EV_EWR] <= 1'b1;
        is_rd <= 1'b0; is_wr <= 1'b0; data_seen <= 1'b0;
        sda_oe <= 1'b0; cnt <= '0; mcnt <= '0; acc <= '0;
        if (stop_det) begin
          phase <= PH_IDLE;
          sel10 <= 1'b0;
        end else begin
          phase <= PH_ADR1;
        end
      end else if (phase == PH_RD) begin
        if (scl_rise) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd8) rack <= sda_s;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
          end else if (cnt == 4'd9) begin
            if (!rack) begin
              tx <= rd_data; sda_oe <= ~rd_data[7]; cnt <= '0;
              ptr <= ptr + 1'b1; ev_set[EV_RRQ] <= 1'b1;
            end else begin
              sda_oe <= 1'b0; phase <= PH_HUNT;
            end
          end else if (cnt != 4'd0) begin
            sda_oe <= ~tx[bidx];
          end
        end
      end else if (phase != PH_IDLE && phase != PH_HUNT) begin
        if (scl_rise && cnt != 4'd9) begin
          cnt <= cnt + 4'd1;
          if (cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
        end else if (scl_fall && cnt == 4'd8) begin
          unique case (phase)
            PH_ADR1: begin
              if (!addr10) begin
                if (hit7) begin
                  sda_oe <= 1'b1;
                  if (shreg[0]) begin
                    is_rd <= 1'b1; ev_set[EV_MRD] <= 1'b1; nxt <= PH_RD;
                  end else begin
                    is_wr <= 1'b1; ev_set[EV_MWR] <= 1'b1; nxt <= after_addr;
                  end
                end else phase <= PH_HUNT;
              end else if (hit10hi && !shreg[0]) begin
                sda_oe <= 1'b1; nxt <= PH_ADR2;
              end else if (hit10hi && sel10) begin
                sda_oe <= 1'b1; is_rd <= 1'b1; ev_set[EV_MRD] <= 1'b1; nxt <= PH_RD;
              end else begin
                sel10 <= 1'b0; phase <= PH_HUNT;
              end
            end
            PH_ADR2: begin
              if (shreg == own_addr[7:0]) begin
                sda_oe <= 1'b1; sel10 <= 1'b1; is_wr <= 1'b1;
                ev_set[EV_MWR] <= 1'b1; nxt <= after_addr;
              end else begin
                sel10 <= 1'b0; phase <= PH_HUNT;
              end
            end
            PH_MADR: begin
              sda_oe <= 1'b1;
              acc <= acc_new;
              mcnt <= mcnt + 3'd1;
              if (mcnt + 3'd1 == abytes) begin
                ptr <= acc_new[PW-1:0]; mem_addr_q <= acc_new; nxt <= PH_WR;
              end else nxt <= PH_MADR;
            end
            default: begin
              sda_oe <= 1'b1; wr_en <= 1'b1; wr_idx <= ptr; wr_data <= shreg;
              ptr <= ptr + 1'b1; data_seen <= 1'b1;
              ev_set[EV_WRQ] <= 1'b1; nxt <= PH_WR;
            end
          endcase
        end else if (scl_fall && cnt == 4'd9) begin
          cnt <= '0;
          phase <= nxt;
          if (nxt == PH_RD) begin
            tx <= rd_data; sda_oe <= ~rd_data[7];
            ptr <= ptr + 1'b1; ev_set[EV_RRQ] <= 1'b1;
          end else sda_oe <= 1'b0;
        end
      end else begin
        sda_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_regtarget.sv
module i2c_regtarget
  import i2c_tgt_pkg::*;
#(
  parameter int MEM_DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [5:0] TRIG_RESET = 6'b110000,
  localparam int PW = $clog2(MEM_DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [9:0]  own_addr,
  input  logic        addr10,
  input  logic [2:0]  mem_abytes,
  input  logic        trig_mask_we,
  input  logic [5:0]  trig_mask_wdata,
  input  logic [5:0]  evt_clr,
  output logic [5:0]  evt_flags,
  output logic        irq,
  output logic [31:0] mem_addr_q
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [2:0] abytes_c;
  logic [PW-1:0] ptr, wr_idx;
  logic wr_en;
  logic [7:0] wr_data, rd_data;
  logic [NUM_EV-1:0] ev_set;
  phase_t phase;

  assign abytes_c = (mem_abytes > 3'd4) ? 3'd4 : mem_abytes;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .scl_s, .sda_s,
    .scl_rise, .scl_fall, .start_det, .stop_det
  );

  i2c_tgt_engine #(.DEPTH(MEM_DEPTH)) u_eng (
    .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .own_addr, .addr10, .abytes(abytes_c), .rd_data, .ptr, .wr_en,
    .wr_idx, .wr_data, .sda_oe, .ev_set, .mem_addr_q, .phase
  );

  i2c_tgt_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk, .rst_n, .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ridx(ptr), .rdata(rd_data)
  );

  i2c_tgt_events #(.NEV(NUM_EV), .MASK_RST(TRIG_RESET)) u_evt (
    .clk, .rst_n, .set(ev_set), .clr(evt_clr), .mask_we(trig_mask_we),
    .mask_wdata(trig_mask_wdata), .flags(evt_flags), .irq
  );
endmodule

// File: rtl/i2c_regtarget_chk.sv
module i2c_regtarget_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input phase_t     phase,
  input logic [5:0] ev_set,
  input logic [5:0] evt_flags,
  input logic [5:0] evt_clr,
  input logic       irq
);
  // R10: drive changes only in SCL low, or on START/STOP release
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));
  // R10: released in idle
  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);
  // R6: at most one event raised per cycle
  p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_set));
  // R6: a raised event shows up in the flags
  p_set_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != 6'd0) |=> ((evt_flags & $past(ev_set)) == $past(ev_set)));
  // R8: flags not cleared stay set
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_flags & $past(evt_flags & ~evt_clr)) == $past(evt_flags & ~evt_clr)));
  // R9: interrupt needs some flag
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_flags != 6'd0));
endmodule

bind i2c_regtarget i2c_regtarget_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(u_sync.scl_s), .start_det(u_sync.start_det),
  .stop_det(u_sync.stop_det), .sda_oe(sda_oe), .phase(u_eng.phase),
  .ev_set(u_eng.ev_set), .evt_flags(evt_flags), .evt_clr(evt_clr), .irq(irq)
);

// File: tb/i2c_regtarget_tb.sv
`timescale 1ns/1ps
module i2c_regtarget_tb;
  localparam time Q = 40ns;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_ctl = 1'b1;
  logic sda_oe, irq, addr10 = 1'b0, trig_mask_we = 1'b0;
  logic [9:0] own_addr = 10'h052;
  logic [2:0] mem_abytes = 3'd1;
  logic [5:0] trig_mask_wdata = '0, evt_clr = '0, evt_flags;
  logic [31:0] mem_addr_q;
  wire sda_line = sda_ctl & ~sda_oe;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string exp_tag[$];
  logic [7:0] rd_val;
  event rd_ev;

  always #2ns clk = ~clk;

  i2c_regtarget u_dut (
    .clk, .rst_n, .scl_i(scl), .sda_i(sda_line), .sda_oe, .own_addr, .addr10,
    .mem_abytes, .trig_mask_we, .trig_mask_wdata, .evt_clr, .evt_flags, .irq,
    .mem_addr_q
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as they are produced
  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) chk(32'(rd_val), 32'hFFFF, "R5 unexpected byte");
    else chk(32'(rd_val), 32'(exp_q.pop_front()), exp_tag.pop_front());
  end

  task automatic wbit(input logic v);
    sda_ctl = v; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask
  task automatic start_c();
    sda_ctl = 1'b1; #Q; scl = 1'b1; #Q; sda_ctl = 1'b0; #Q; scl = 1'b0; #Q;
  endtask
  task automatic stop_c();
    sda_ctl = 1'b0; #Q; scl = 1'b1; #Q; sda_ctl = 1'b1; #(2*Q);
  endtask
  task automatic wbyte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    sda_ctl = 1'b1; #Q; scl = 1'b1; #Q; a = ~sda_line; #Q; scl = 1'b0; #Q;
    chk(32'(a), 32'(exp_ack), tag);
  endtask
  // driver: pushes the expected byte, then reads it
  task automatic rbyte(input logic [7:0] exp, input logic ack_it, input string tag);
    logic [7:0] b = '0;
    exp_q.push_back(exp); exp_tag.push_back(tag);
    sda_ctl = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #Q; scl = 1'b1; #Q; b = {b[6:0], sda_line}; #Q; scl = 1'b0; #Q;
    end
    rd_val = b; -> rd_ev;
    wbit(~ack_it);
    sda_ctl = 1'b1;
    if (!ack_it) chk(32'(sda_oe), 0, "R5 released after NACK");
  endtask
  task automatic clear_all();
    @(negedge clk); evt_clr = 6'h3F; @(negedge clk); evt_clr = 6'h00; @(negedge clk);
  endtask
  task automatic set_mask(input logic [5:0] m);
    @(negedge clk); trig_mask_we = 1'b1; trig_mask_wdata = m;
    @(negedge clk); trig_mask_we = 1'b0; @(negedge clk);
  endtask

  initial begin
    #400us;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #21ns rst_n = 1'b1; #20ns;
    chk(32'(sda_oe), 0, "R10 reset sda_oe");
    chk(32'(evt_flags), 0, "R8 reset flags");
    chk(32'(irq), 0, "R9 reset irq");
    chk(mem_addr_q, 0, "R3 reset mem_addr_q");

    // R1: foreign address is NACKed, no flags
    start_c(); wbyte(8'hA6, 1'b0, "R1 foreign NACK"); stop_c();
    chk(32'(evt_flags), 0, "R1 no flags after NACK");

    // R4: write with wrap, 1 address byte
    start_c(); wbyte(8'hA4, 1'b1, "R1 own ACK");
    wbyte(8'h0E, 1'b1, "R3 addr ACK");
    wbyte(8'hAA, 1'b1, "R4 data ACK"); wbyte(8'hBB, 1'b1, "R4 data ACK");
    wbyte(8'hCC, 1'b1, "R4 data ACK wrap"); stop_c();
    chk(32'(evt_flags), 32'h2A, "R6 write flags");
    chk(32'(irq), 1, "R9 irq default mask end write");
    chk(mem_addr_q, 32'h0E, "R3 mem_addr_q");
    clear_all();
    chk(32'(evt_flags), 0, "R8 clear all");

    // R7: address-only write suppresses end of write
    start_c(); wbyte(8'hA4, 1'b1, "R1 ACK"); wbyte(8'h0F, 1'b1, "R3 ACK"); stop_c();
    chk(32'(evt_flags), 32'h02, "R7 end write suppressed");
    chk(32'(irq), 0, "R9 match write masked");
    clear_all();

    // R5: read with wrap, ACK ACK NACK
    start_c(); wbyte(8'hA5, 1'b1, "R1 read ACK");
    rbyte(8'hBB, 1'b1, "R5 byte 0F"); rbyte(8'hCC, 1'b1, "R4 R5 wrapped byte 00");
    rbyte(8'h00, 1'b0, "R5 byte 01"); stop_c();
    chk(32'(evt_flags), 32'h15, "R6 read flags");

    // R9: mask loads
    set_mask(6'h01); chk(32'(irq), 1, "R9 mask match read");
    set_mask(6'h00); chk(32'(irq), 0, "R9 mask zero");
    set_mask(6'h30);
    // R8: partial clear
    @(negedge clk); evt_clr = 6'h01; @(negedge clk); evt_clr = 6'h00; @(negedge clk);
    chk(32'(evt_flags), 32'h14, "R8 partial clear");
    clear_all();

    // R7: address write, repeated START, read
    start_c(); wbyte(8'hA4, 1'b1, "R1 ACK"); wbyte(8'h00, 1'b1, "R3 ACK");
    start_c(); wbyte(8'hA5, 1'b1, "R1 Sr ACK");
    rbyte(8'hCC, 1'b1, "R5 Sr byte 00"); rbyte(8'h00, 1'b0, "R5 Sr byte 01"); stop_c();
    chk(32'(evt_flags), 32'h17, "R7 Sr flags");
    clear_all();

    // R3: two and four address bytes, and clamp
    mem_abytes = 3'd2;
    start_c(); wbyte(8'hA4, 1'b1, "R1 ACK"); wbyte(8'h12, 1'b1, "R3 ACK");
    wbyte(8'h34, 1'b1, "R3 ACK"); wbyte(8'h5A, 1'b1, "R4 ACK"); stop_c();
    chk(mem_addr_q, 32'h1234, "R3 two-byte address");
    start_c(); wbyte(8'hA4, 1'b1, "R1 ACK"); wbyte(8'h00, 1'b1, "R3 ACK");
    wbyte(8'h04, 1'b1, "R3 ACK"); start_c(); wbyte(8'hA5, 1'b1, "R1 ACK");
    rbyte(8'h5A, 1'b0, "R3 two-byte readback"); stop_c();
    mem_abytes = 3'd4;
    start_c(); wbyte(8'hA4, 1'b1, "R1 ACK");
    wbyte(8'hDE, 1'b1, "R3 ACK"); wbyte(8'hAD, 1'b1, "R3 ACK");
    wbyte(8'hBE, 1'b1, "R3 ACK"); wbyte(8'hE3, 1'b1, "R3 ACK");
    wbyte(8'h77, 1'b1, "R4 ACK"); stop_c();
    chk(mem_addr_q, 32'hDEADBEE3, "R3 four-byte address");
    mem_abytes = 3'd5;
    start_c(); wbyte(8'hA4, 1'b1, "R1 ACK");
    for (int i = 0; i < 3; i++) wbyte(8'h00, 1'b1, "R3 clamp ACK");
    wbyte(8'h03, 1'b1, "R3 clamp ACK"); start_c(); wbyte(8'hA5, 1'b1, "R1 ACK");
    rbyte(8'h77, 1'b0, "R3 clamped count readback"); stop_c();
    chk(mem_addr_q, 32'h3, "R3 clamped address");
    clear_all();

    // R2: 10-bit addressing
    addr10 = 1'b1; own_addr = 10'h2A5; mem_abytes = 3'd1;
    start_c(); wbyte(8'hF4, 1'b1, "R2 first ACK"); wbyte(8'hA4, 1'b0, "R2 second NACK");
    stop_c();
    chk(32'(evt_flags), 0, "R2 no flags on wrong second byte");
    start_c(); wbyte(8'hF4, 1'b1, "R2 first ACK"); wbyte(8'hA5, 1'b1, "R2 second ACK");
    wbyte(8'h07, 1'b1, "R3 ACK"); wbyte(8'h99, 1'b1, "R4 ACK"); stop_c();
    start_c(); wbyte(8'hF4, 1'b1, "R2 ACK"); wbyte(8'hA5, 1'b1, "R2 ACK");
    wbyte(8'h07, 1'b1, "R3 ACK"); start_c(); wbyte(8'hF5, 1'b1, "R2 Sr read ACK");
    rbyte(8'h99, 1'b0, "R2 10-bit readback"); stop_c();
    chk(32'(evt_flags), 32'h2F | 32'h10, "R2 R6 10-bit flags");
    clear_all();

    // R7: zero address bytes, end of write always
    addr10 = 1'b0; own_addr = 10'h052; mem_abytes = 3'd0;
    start_c(); wbyte(8'hA4, 1'b1, "R1 ACK"); stop_c();
    chk(32'(evt_flags), 32'h22, "R7 empty write keeps end write");
    clear_all();
    start_c(); wbyte(8'hA4, 1'b1, "R1 ACK"); wbyte(8'h3C, 1'b1, "R4 ACK at pointer 8");
    stop_c();
    chk(32'(evt_flags), 32'h2A, "R7 R6 zero-address write flags");
    chk(32'(sda_oe), 0, "R10 idle release");

    #100ns;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule